// File: doc/BRIEF.md
# Clock, reset and power-mode controller

This block sits between the raw oscillator input and the rest of a small microcontroller. Every register in it runs on the rising edge of the oscillator. A divide-by-two flip-flop splits each internal state into two phases, P1 and P2, each one oscillator cycle long. Because only rising edges are used, the duty cycle of the input clock does not matter. Six states of two phases make a machine cycle of 12 oscillator cycles. The block exposes the current state one-hot, the current phase, and a one-cycle strobe in the last phase of every machine cycle.

An external reset request is qualified. The internal core reset is granted only after the request has been sampled high for two whole machine cycles (24 oscillator cycles). The I/O force-high output follows the raw request at once. Software sets the idle and power-down mode bits through single-cycle request pulses:

- Idle removes the CPU clock enable and keeps the peripheral clock enable. An enabled interrupt ends idle at a machine-cycle boundary.
- Power-down removes both enables and freezes the cycle timing. Only a qualified hardware reset ends it.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After each rising edge of `osc_i` the phase toggles between P1 (`phase_o`=0) and P2 (`phase_o`=1). The state advances one step only after P2. `state_o` is one-hot, bit 0 = S1 through bit 5 = S6, and S6 wraps to S1.
- R2: `mc_stb_o` is high only during S6/P2 while the timing runs. That is one oscillator cycle in every 12.
- R3: `core_rst_o` rises after `ext_rst_i` has been sampled high on 24 consecutive rising edges. It falls after the first edge that samples `ext_rst_i` low.
- R4: If `ext_rst_i` falls before 24 high samples, no internal reset occurs. The qualification count starts again from zero on the next high.
- R5: `io_high_o` is high whenever `ext_rst_i` or `core_rst_o` is high, with no clock delay from `ext_rst_i`.
- R6: An `idle_req_i` pulse drives `cpu_clk_en_o` low from the next cycle. `per_clk_en_o` stays high and the state/phase timing keeps running.
- R7: In idle, if `irq_pend_i` is high in the cycle that carries `mc_stb_o`, idle ends at that edge. `cpu_clk_en_o` is high again from S1/P1.
- R8: A `pdown_req_i` pulse drives both clock enables low from the next cycle. While power-down lasts, `state_o` and `phase_o` hold their values, `mc_stb_o` stays low and `irq_pend_i` has no effect.
- R9: While `core_rst_o` is high, the timing is held at S1/P1 and both mode bits are cleared. The first cycle after release is S1/P1, with both clock enables high.
- R10: Idle and power-down requests that arrive while `core_rst_o` is high are ignored.
- R11: After the asynchronous `rst_ni` reset, the outputs read S1/P1 with both clock enables high, and `core_rst_o` and `mc_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | External reset request, synchronous to `osc_i` |
| idle_req_i | input | 1 | One-cycle request to enter idle |
| pdown_req_i | input | 1 | One-cycle request to enter power-down |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| state_o | output | 6 | One-hot machine state S1..S6 |
| phase_o | output | 1 | Phase within state: 0 = P1, 1 = P2 |
| mc_stb_o | output | 1 | Machine-cycle end strobe |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| core_rst_o | output | 1 | Qualified internal reset |
| io_high_o | output | 1 | Forces port pins high |

## Verification
The assertions take for granted that `ext_rst_i`, `idle_req_i`, `pdown_req_i` and `irq_pend_i` are already synchronous to `osc_i`. They also take for granted that the mode requests are single-cycle pulses, as a register write would produce. The bench changes every input only on the falling edge of `osc_i`, and it pulses each request for exactly one cycle. Reset pulses are placed both just short of the qualification length and well past it. Interrupts are raised during idle, during power-down and during an active reset, so that the boundary wake-up can be told apart from the cases where the interrupt must be ignored.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int unsigned NUM_STATES_DEF = 6;
  localparam int unsigned QUAL_MC_DEF    = 2;

  typedef enum logic {
    PH_P1 = 1'b0,
    PH_P2 = 1'b1
  } phase_e;
endpackage

// File: rtl/cyc_timer.sv
module cyc_timer
  import clk_pwr_pkg::*;
#(
  parameter int unsigned NUM_STATES = NUM_STATES_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hold_i,
  input  logic                  freeze_i,
  output logic [NUM_STATES-1:0] state_o,
  output logic                  phase_o,
  output logic                  mc_stb_o
);
  localparam int unsigned ST_W = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1;
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(NUM_STATES - 1);

  phase_e          ph_q;
  logic [ST_W-1:0] st_q;

  // divide-by-two stage: phase flop toggles on every oscillator edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_P1;
      st_q <= '0;
    end else if (hold_i) begin
      ph_q <= PH_P1;
      st_q <= '0;
    end else if (!freeze_i) begin
      ph_q <= (ph_q == PH_P1) ? PH_P2 : PH_P1;
      if (ph_q == PH_P2) st_q <= (st_q == ST_LAST) ? '0 : st_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_onehot
    assign state_o[g] = (st_q == ST_W'(g));
  end

  assign phase_o  = ph_q;
  assign mc_stb_o = (st_q == ST_LAST) && (ph_q == PH_P2) && !freeze_i && !hold_i;

  assert_state_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);
  assert_phase_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i && !freeze_i |=> phase_o != $past(phase_o));
  assert_freeze_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i && !hold_i |=> $stable(state_o) && $stable(phase_o));
  assert_hold_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> state_o[0] && !phase_o);
endmodule

// File: rtl/rst_qual.sv
module rst_qual #(
  parameter int unsigned QUAL_LEN = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  output logic core_rst_o
);
  localparam int unsigned CNT_W = $clog2(QUAL_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(QUAL_LEN);

  logic [CNT_W-1:0] cnt_q;

  // a low sample restarts the count from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!ext_rst_i)     cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign core_rst_o = (cnt_q == CNT_TOP);

  assert_rst_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(ext_rst_i));
  assert_rst_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o && !ext_rst_i |=> !core_rst_o);
  assert_short_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_i |=> !core_rst_o);
endmodule

// File: rtl/pwr_mode.sv
module pwr_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic idle_set_i,
  input  logic pd_set_i,
  input  logic irq_i,
  input  logic bnd_i,
  output logic idle_o,
  output logic pd_o
);
  logic idle_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (clr_i) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      if (pd_set_i) pd_q <= 1'b1;
      if (idle_set_i)          idle_q <= 1'b1;
      else if (bnd_i && irq_i) idle_q <= 1'b0;
    end
  end

  assign idle_o = idle_q;
  assign pd_o   = pd_q;

  assert_wake_on_bnd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_q) |-> $past(clr_i) || ($past(bnd_i) && $past(irq_i)));
  assert_pd_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q && !clr_i |=> pd_q);
  assert_clr_modes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !idle_q && !pd_q);
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
#(
  parameter int unsigned NUM_STATES = NUM_STATES_DEF,
  parameter int unsigned QUAL_MC    = QUAL_MC_DEF
) (
  input  logic                  osc_i,
  input  logic                  rst_ni,
  input  logic                  ext_rst_i,
  input  logic                  idle_req_i,
  input  logic                  pdown_req_i,
  input  logic                  irq_pend_i,
  output logic [NUM_STATES-1:0] state_o,
  output logic                  phase_o,
  output logic                  mc_stb_o,
  output logic                  cpu_clk_en_o,
  output logic                  per_clk_en_o,
  output logic                  core_rst_o,
  output logic                  io_high_o
);
  localparam int unsigned OSC_PER_MC = 2 * NUM_STATES;
  localparam int unsigned QUAL_LEN   = QUAL_MC * OSC_PER_MC;

  logic core_rst, idle, pd, stb;

  rst_qual #(.QUAL_LEN(QUAL_LEN)) u_rst_qual (
    .clk_i     (osc_i),
    .rst_ni    (rst_ni),
    .ext_rst_i (ext_rst_i),
    .core_rst_o(core_rst)
  );

  cyc_timer #(.NUM_STATES(NUM_STATES)) u_cyc_timer (
    .clk_i   (osc_i),
    .rst_ni  (rst_ni),
    .hold_i  (core_rst),
    .freeze_i(pd),
    .state_o (state_o),
    .phase_o (phase_o),
    .mc_stb_o(stb)
  );

  pwr_mode u_pwr_mode (
    .clk_i     (osc_i),
    .rst_ni    (rst_ni),
    .clr_i     (core_rst),
    .idle_set_i(idle_req_i),
    .pd_set_i  (pdown_req_i),
    .irq_i     (irq_pend_i),
    .bnd_i     (stb),
    .idle_o    (idle),
    .pd_o      (pd)
  );

  assign mc_stb_o     = stb;
  assign cpu_clk_en_o = !idle && !pd;
  assign per_clk_en_o = !pd;
  assign core_rst_o   = core_rst;
  // pins forced high before qualification completes
  assign io_high_o    = ext_rst_i || core_rst;

  assert_idle_keeps_per_R6: assert property (@(posedge osc_i) disable iff (!rst_ni)
    !cpu_clk_en_o && per_clk_en_o |-> $past(state_o) != state_o || $past(phase_o) != phase_o
      || $past(core_rst));
  assert_pd_no_stb_R8: assert property (@(posedge osc_i) disable iff (!rst_ni)
    !per_clk_en_o |-> !mc_stb_o);
  assert_io_high_R5: assert property (@(posedge osc_i) disable iff (!rst_ni)
    core_rst_o |-> io_high_o);
endmodule

// File: tb/clk_pwr_ctrl_bench.sv
module clk_pwr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_rst = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq = 1'b0;
  logic [5:0] state;
  logic       phase, mc_stb, cpu_en, per_en, core_rst, io_high;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_ph, m_st, m_cnt;
  bit m_idle, m_pd;

  always #2.5 clk = ~clk;

  clk_pwr_ctrl u_clk_pwr_ctrl (
    .osc_i(clk), .rst_ni(rst_n), .ext_rst_i(ext_rst), .idle_req_i(idle_req),
    .pdown_req_i(pd_req), .irq_pend_i(irq), .state_o(state), .phase_o(phase),
    .mc_stb_o(mc_stb), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .core_rst_o(core_rst), .io_high_o(io_high)
  );

  function automatic bit m_rint();
    return m_cnt == 24;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_cnt = 0; m_idle = 0; m_pd = 0;
    end else begin
      bit rint, bnd, pd_old;
      rint   = m_rint();
      pd_old = m_pd;
      bnd    = (m_st == 5) && (m_ph == 1) && !pd_old && !rint;
      if (rint) begin
        m_ph = 0; m_st = 0; m_idle = 0; m_pd = 0;
      end else begin
        if (!pd_old) begin
          if (m_ph == 1) m_st = (m_st + 1) % 6;
          m_ph = 1 - m_ph;
        end
        if (pd_req) m_pd = 1;
        if (idle_req) m_idle = 1;
        else if (bnd && irq) m_idle = 0;
      end
      m_cnt = ext_rst ? ((m_cnt < 24) ? m_cnt + 1 : 24) : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit rint;
    rint = m_rint();
    chk("R1 state", int'(state), 1 << m_st);
    chk("R1 phase", int'(phase), m_ph);
    chk("R2 mc_stb", int'(mc_stb), int'((m_st == 5) && (m_ph == 1) && !m_pd && !rint));
    chk("R3 core_rst", int'(core_rst), int'(rint));
    chk("R5 io_high", int'(io_high), int'(ext_rst || rint));
    chk("R6 cpu_en", int'(cpu_en), int'(!m_idle && !m_pd));
    chk("R8 per_en", int'(per_en), int'(!m_pd));
  endtask

  // one cycle: compare at falling edge, then drive next inputs
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_idle();
    idle_req = 1'b1; step(); idle_req = 1'b0;
  endtask

  task automatic pulse_pd();
    pd_req = 1'b1; step(); pd_req = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 state", int'(state), 1);
    chk("R11 cpu_en", int'(cpu_en), 1);
    chk("R11 core_rst", int'(core_rst), 0);
    rst_n = 1'b1;
    run(30);

    // R6 idle, R7 wake at boundary
    pulse_idle();
    chk("R6 cpu_en low", int'(cpu_en), 0);
    run(17);
    irq = 1'b1; run(14); irq = 1'b0;
    chk("R7 woke", int'(cpu_en), 1);
    run(10);

    // R4 short reset pulses
    ext_rst = 1'b1; run(20); ext_rst = 1'b0; run(2);
    chk("R4 no reset", int'(core_rst), 0);
    ext_rst = 1'b1; run(23); ext_rst = 1'b0; run(1);
    chk("R4 restart", int'(core_rst), 0);
    run(5);

    // R8 power-down, irq ignored
    pulse_pd();
    chk("R8 per_en low", int'(per_en), 0);
    irq = 1'b1; run(30); irq = 1'b0;
    chk("R8 still down", int'(cpu_en), 0);

    // R3/R9 hardware reset ends power-down; R10 requests ignored inside reset
    ext_rst = 1'b1; run(26);
    chk("R3 core_rst", int'(core_rst), 1);
    pulse_idle(); pulse_pd(); irq = 1'b1; run(4); irq = 1'b0;
    ext_rst = 1'b0; run(1);
    chk("R9 state S1", int'(state), 1);
    chk("R10 cpu_en", int'(cpu_en), 1);
    run(20);

    // idle then power-down on top, then reset out
    pulse_idle(); run(7); pulse_pd(); run(15);
    ext_rst = 1'b1; run(30); ext_rst = 1'b0; run(30);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule